// File: doc/BRIEF.md
# Programmable Running-Light Controller

This block drives an 8-bit LED output from a pattern that software loads through a small word-addressed register bus. Every N clock cycles it moves the pattern one place. The active mode chooses how it moves: it rotates toward the high bit, rotates toward the low bit, sweeps back and forth, or holds still. The back-and-forth sweep does not lose bits at either edge of the window. Bits that slide out of the window are kept in a stored base pattern. They come back on the return sweep, so the loaded pattern reappears exactly.

The LED value is computed as a stored base pattern shifted by a signed offset, and positions left empty by the shift show zero. A rotating step folds the shown value back into the base and clears the offset. Because of this, moving between modes never shows a value that was not produced by a programmed pattern.

After reset the block sweeps back and forth on pattern 0x1B, using a default step interval. It needs only a clock, a synchronous active-high reset and the register bus.

Top module: `run_light`

## Requirements
- R1: After reset the LED output is 0x1B, the mode register reads 2 (sweep), the delay register reads the RST_DELAY parameter and the pattern register reads 0x1B.
- R2: In mode 0 every step rotates the LED value one place toward bit 7, and the old bit 7 enters bit 0.
- R3: In mode 1 every step rotates the LED value one place toward bit 0, and the old bit 0 enters bit 7.
- R4: In mode 2, starting from a freshly loaded pattern, the first seven steps shift left one place each and fill bit 0 with zero. After the seventh step the original bit 0 sits at bit 7.
- R5: Mode 2 then shifts right. The kept bits re-enter at bit 7 until the loaded pattern is shown again. The shift continues until the original bit 7 sits at bit 0 (seven places right), and then the sweep turns left again.
- R6: In mode 3 the LED output holds its value for any number of cycles.
- R7: Word 0 reads the last written pattern in bits 7:0, word 1 reads the mode in bits 1:0, word 2 reads the delay, and word 3 reads the current LED value. A write to word 3 changes no register and no LED bit.
- R8: A write to word 0 shows the new pattern on the LED output from the next cycle on, and restarts the sweep at offset zero heading left.
- R9: A write to word 2 restarts the interval count. The first step after the write lands exactly N clock edges after the write edge, and later steps follow every N edges.
- R10: A delay of 0 behaves as a delay of 1, so a step happens on every clock edge.
- R11: The LED output changes only on a step edge or on a pattern write, and never between steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word index: 0 pattern, 1 mode, 2 delay, 3 LED status (byte offsets 0x0 to 0xC) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at addr, combinational |
| led | output | 8 | LED drive value |

## Verification
The bench runs the sweep through a full round trip, from offset 0 to +7, down to -7 and back up. A design that wrapped the spilled bits or dropped them would fail to restore the pattern on the way back, and one that reversed a step early or late would fail the check at the turning point. It also writes a new pattern in the middle of a sweep: a design that kept the old offset or direction would show a shifted copy of the new pattern. It changes the delay while the light is running and also sets a zero delay. A counter that was not restarted would produce a step at the wrong edge, and a zero delay taken literally would hang the light. Stability is checked on every cycle between steps, so any intermediate or unprogrammed value shows up.

// File: rtl/run_light.sv
module run_light #(
  parameter int LED_W = 8,
  parameter int DATA_W = 32,
  parameter logic [LED_W-1:0] RST_PATTERN = 'h1B,
  parameter logic [DATA_W-1:0] RST_DELAY = 'd6_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [LED_W-1:0]  led
);
  localparam int OFF_W = $clog2(LED_W) + 1;
  localparam logic signed [OFF_W-1:0] OFF_MAX = OFF_W'(LED_W - 1);
  localparam logic signed [OFF_W-1:0] OFF_ONE = 1;
  localparam logic [DATA_W-1:0] D_ONE = 1;

  typedef enum logic [1:0] {M_ROTL = 2'd0, M_ROTR = 2'd1, M_PING = 2'd2, M_HOLD = 2'd3} mode_t;

  logic [LED_W-1:0]        pat_q, base_q;
  logic signed [OFF_W-1:0] off_q, off_nx;
  logic                    dir_left;
  mode_t                   mode_q;
  logic [DATA_W-1:0]       dly_q, cnt_q, n_eff;
  logic                    pat_wr, mode_wr, dly_wr, tick, step_fire;

  function automatic logic [LED_W-1:0] place(input logic [LED_W-1:0] b,
                                             input logic signed [OFF_W-1:0] o);
    logic [OFF_W-1:0] m;
    m = o[OFF_W-1] ? $unsigned(-o) : $unsigned(o);
    return o[OFF_W-1] ? (b >> m) : (b << m);
  endfunction

  assign pat_wr    = wr_en && (addr == 2'd0);
  assign mode_wr   = wr_en && (addr == 2'd1);
  assign dly_wr    = wr_en && (addr == 2'd2);
  assign n_eff     = (dly_q == '0) ? D_ONE : dly_q;
  assign tick      = cnt_q >= (n_eff - D_ONE);
  assign step_fire = tick && !pat_wr && !dly_wr;
  assign off_nx    = dir_left ? (off_q + OFF_ONE) : (off_q - OFF_ONE);
  assign led       = place(base_q, off_q);

  always_comb begin
    case (addr)
      2'd0:    rdata = DATA_W'(pat_q);
      2'd1:    rdata = DATA_W'(mode_q);
      2'd2:    rdata = dly_q;
      default: rdata = DATA_W'(led);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q    <= RST_PATTERN;
      base_q   <= RST_PATTERN;
      off_q    <= '0;
      dir_left <= 1'b1;
      mode_q   <= M_PING;
      dly_q    <= RST_DELAY;
      cnt_q    <= '0;
    end else begin
      cnt_q <= (tick || dly_wr) ? '0 : cnt_q + D_ONE;
      if (mode_wr) mode_q <= mode_t'(wdata[1:0]);
      if (dly_wr)  dly_q  <= wdata;
      if (pat_wr) begin
        pat_q    <= wdata[LED_W-1:0];
        base_q   <= wdata[LED_W-1:0];
        off_q    <= '0;
        dir_left <= 1'b1;
      end else if (step_fire) begin
        case (mode_q)
          M_ROTL: begin
            base_q   <= {led[LED_W-2:0], led[LED_W-1]};
            off_q    <= '0;
            dir_left <= 1'b1;
          end
          M_ROTR: begin
            base_q   <= {led[0], led[LED_W-1:1]};
            off_q    <= '0;
            dir_left <= 1'b1;
          end
          M_PING: begin
            off_q <= off_nx;
            if (off_nx == OFF_MAX)       dir_left <= 1'b0;
            else if (off_nx == -OFF_MAX) dir_left <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assert_hold_between_steps_R11: assert property (@(posedge clk) disable iff (rst)
    (!step_fire && !pat_wr) |=> $stable(led));

  assert_stop_freezes_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_HOLD && !pat_wr) |=> $stable(led));

  assert_pattern_load_R8: assert property (@(posedge clk) disable iff (rst)
    pat_wr |=> (led == $past(wdata[LED_W-1:0]) && off_q == '0 && dir_left));

  assert_delay_restart_R9: assert property (@(posedge clk) disable iff (rst)
    dly_wr |=> (cnt_q == '0));

  assert_rotl_step_R2: assert property (@(posedge clk) disable iff (rst)
    (step_fire && mode_q == M_ROTL) |=> (led == {$past(led[LED_W-2:0]), $past(led[LED_W-1])}));

  assert_offset_span_R4: assert property (@(posedge clk) disable iff (rst)
    (off_q <= OFF_MAX && off_q >= -OFF_MAX));
endmodule

// File: tb/run_light_tb_top.sv
module run_light_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  led;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  run_light #(.RST_DELAY(32'd3)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .led(led)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  function automatic logic [7:0] place8(input logic [7:0] p, input int o);
    return (o >= 0) ? (p << o) : (p >> (-o));
  endfunction

  task automatic push_rot(input logic [7:0] p, input bit left, input int n);
    logic [7:0] v = p;
    for (int i = 0; i < n; i++) begin
      v = left ? {v[6:0], v[7]} : {v[0], v[7:1]};
      exp_q.push_back(v);
    end
  endtask

  task automatic push_pp(input logic [7:0] p, input int n);
    int o = 0;
    bit dl = 1'b1;
    for (int i = 0; i < n; i++) begin
      o = dl ? o + 1 : o - 1;
      if (o == 7) dl = 1'b0;
      if (o == -7) dl = 1'b1;
      exp_q.push_back(place8(p, o));
    end
  endtask

  // monitor: every d edges pop one expected value; in between the value must hold
  task automatic monitor_steps(input string req, input int d, input int n);
    logic [7:0] prev = led;
    logic [7:0] e;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < d - 1; k++) begin
        @(negedge clk);
        check("R11 hold", {24'h0, led}, {24'h0, prev});
      end
      @(negedge clk);
      e = exp_q.pop_front();
      check(req, {24'h0, led}, {24'h0, e});
      prev = led;
    end
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 led", {24'h0, led}, 32'h1B);
    rd_check("R1 pattern", 2'd0, 32'h1B);
    rd_check("R1 mode", 2'd1, 32'h2);
    rd_check("R1 delay", 2'd2, 32'd3);
    rd_check("R7 status", 2'd3, 32'h1B);
    @(negedge clk);

    // R4 / R5 full sweep round trip from the reset pattern
    wr(2'd2, 32'd2);
    push_pp(8'h1B, 28);
    monitor_steps("R4 sweep out", 2, 7);
    monitor_steps("R5 sweep back", 2, 21);

    // R2 rotate left
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h96);
    wr(2'd2, 32'd4);
    push_rot(8'h96, 1'b1, 9);
    monitor_steps("R2 rotl", 4, 9);

    // R3 rotate right
    wr(2'd1, 32'd1);
    wr(2'd0, 32'h2C);
    wr(2'd2, 32'd3);
    push_rot(8'h2C, 1'b0, 9);
    monitor_steps("R3 rotr", 3, 9);

    // R10 zero delay steps every edge
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h01);
    wr(2'd2, 32'd0);
    push_rot(8'h01, 1'b1, 10);
    monitor_steps("R10 zero delay", 1, 10);
    rd_check("R7 delay zero", 2'd2, 32'd0);

    // R9 delay changes while running
    v = led;
    wr(2'd2, 32'd5);
    push_rot(v, 1'b1, 3);
    monitor_steps("R9 delay 5", 5, 3);
    v = led;
    wr(2'd2, 32'd2);
    push_rot(v, 1'b1, 3);
    monitor_steps("R9 delay 2", 2, 3);

    // R8 pattern load and sweep restart
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h5A);
    check("R8 load", {24'h0, led}, 32'h5A);
    wr(2'd2, 32'd3);
    push_pp(8'h5A, 10);
    monitor_steps("R8 sweep", 3, 10);
    wr(2'd0, 32'hE1);
    check("R8 reload", {24'h0, led}, 32'hE1);
    wr(2'd2, 32'd3);
    push_pp(8'hE1, 9);
    monitor_steps("R8 restart", 3, 9);

    // R7 readback
    rd_check("R7 pattern", 2'd0, 32'hE1);
    rd_check("R7 mode", 2'd1, 32'h2);
    rd_check("R7 delay", 2'd2, 32'd3);
    rd_check("R7 status", 2'd3, {24'h0, led});
    @(negedge clk);

    // R6 stop freezes, R7 status write ignored
    wr(2'd1, 32'd3);
    v = led;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R6 stop", {24'h0, led}, {24'h0, v});
    end
    wr(2'd3, 32'hFF);
    check("R7 ro led", {24'h0, led}, {24'h0, v});
    rd_check("R7 ro pattern", 2'd0, 32'hE1);
    rd_check("R7 ro mode", 2'd1, 32'h3);
    rd_check("R7 ro delay", 2'd2, 32'd3);
    rd_check("R7 ro status", 2'd3, {24'h0, v});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule